// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer that runs from a slow, low-speed clock. An internal counter advances once per clock cycle. If software does not clear it in time, the block issues a one-cycle timeout reset pulse. An 8-bit control register sets the behaviour. Its upper five bits hold an enable key. Its lower three bits pick a power-of-two timeout. A static mode input chooses between two modes. In one, the watchdog can never be stopped. In the other, software may switch it off with a dedicated key value.

Only two key values are legal. Any other key value is treated as corruption. After a short synchronizer delay, a level reset request is raised and held for as long as the bad key remains. A sticky watchdog-reset flag records both key faults and timeouts. External reset logic clears that flag explicitly.

Top module: `keyed_watchdog`

## Requirements
- R1: After `rst_n` is released, `ctl_rdata` reads 8'h53 (key 5'b01010 in bits 7:3, timeout select 3'b011 in bits 2:0), and `timeout_rst`, `key_rst` and `wd_flag` are all low.
- R2: A write with `ctl_we` high loads `ctl_wdata` into the control register at that clock edge. `ctl_rdata` shows the new value from the next cycle.
- R3: Key 5'b01010 lets the counter run in both modes. Key 5'b10101 also lets it run when `always_on` is 1, but stops it when `always_on` is 0.
- R4: Select code s gives a timeout of 2^k cycles. k is 8 for s=0, 10 for s=1, 12 for s=2, 14 for s=3, and 11+s for s=4..7. A timeout pulse appears exactly 2^k clock edges after the edge on which `kick` was sampled high.
- R5: `timeout_rst` is high for exactly one cycle. The counter then restarts from zero, so with no kick the next pulse follows after another 2^k cycles.
- R6: `kick` sampled high clears the counter and suppresses a timeout on that edge.
- R7: While the watchdog is stopped, the counter stays at zero and `timeout_rst` stays low.
- R8: A key other than 5'b01010 or 5'b10101 raises `key_rst` 2 cycles after the write edge and holds the counter at zero. `key_rst` stays high while the key is bad and falls 2 cycles after a legal key is written.
- R9: `wd_flag` is set on the same edge that `key_rst` or `timeout_rst` goes high. It holds until `flag_clr` is sampled high, and a set in the same cycle wins over the clear.
- R10: If the select field is lowered while the counter already exceeds the new terminal count, the timeout pulse appears on the edge after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| always_on | input | 1 | Mode: 1 means the watchdog cannot be stopped by software |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register contents |
| kick | input | 1 | Clears the timeout counter |
| flag_clr | input | 1 | Clears the watchdog-reset flag |
| timeout_rst | output | 1 | One-cycle timeout reset pulse |
| key_rst | output | 1 | Reset request held while the key is invalid |
| wd_flag | output | 1 | Sticky watchdog-reset flag |

## Verification
If the counter held a wrong value, the timeout pulse would move away from the exact 2^k-edge position measured after a kick. That error appears only at the end of a full timeout window, so each window is counted cycle by cycle. A wrong key decode or a wrong synchronizer depth shows on `key_rst` within two or three cycles of the write. A wrong stop decision shows as a pulse where none is allowed, within one window. Flag faults show on the cycle after a set or a clear.

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int          CNT_W    = 18,
  parameter logic [7:0]  RST_VAL  = 8'h53,
  parameter logic [4:0]  KEY_RUN  = 5'b01010,
  parameter logic [4:0]  KEY_STOP = 5'b10101
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       always_on,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  input  logic       kick,
  input  logic       flag_clr,
  output logic       timeout_rst,
  output logic       key_rst,
  output logic       wd_flag
);

  logic [7:0]       ctl;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] term;
  logic [4:0]       lg;
  logic             key_ok, run, bad, hit, s1, s2;

  assign key_ok = (ctl[7:3] == KEY_RUN) || (ctl[7:3] == KEY_STOP);
  assign bad    = !key_ok;
  assign run    = key_ok && (always_on || ctl[7:3] == KEY_RUN);
  assign lg     = (ctl[2:0] < 3'd3) ? 5'(8 + 2 * ctl[2:0]) : 5'(11 + ctl[2:0]);
  assign term   = ({{(CNT_W-1){1'b0}}, 1'b1} << lg) - 1'b1;
  assign hit    = run && !kick && (cnt >= term);

  assign ctl_rdata = ctl;
  assign key_rst   = s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl         <= RST_VAL;
      cnt         <= '0;
      timeout_rst <= 1'b0;
      s1          <= 1'b0;
      s2          <= 1'b0;
      wd_flag     <= 1'b0;
    end else begin
      if (ctl_we) ctl <= ctl_wdata;
      s1 <= bad;
      s2 <= s1;
      if (!run || kick || hit) cnt <= '0;
      else                     cnt <= cnt + 1'b1;
      timeout_rst <= hit;
      wd_flag     <= (wd_flag & ~flag_clr) | s1 | hit;
    end
  end

  assert_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> ctl_rdata == $past(ctl_wdata));
  assert_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_rst |=> !timeout_rst);
  assert_stopped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !timeout_rst);
  assert_keydelay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_rst) |-> $past(bad, 2));
  assert_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (key_rst || timeout_rst) |-> wd_flag);

endmodule

// File: tb/sim_keyed_watchdog.sv
module sim_keyed_watchdog;
  logic clk = 0, rst_n = 0, always_on = 0, ctl_we = 0, kick = 0, flag_clr = 0;
  logic [7:0] ctl_wdata = 0, ctl_rdata;
  logic timeout_rst, key_rst, wd_flag;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  keyed_watchdog u0 (.clk, .rst_n, .always_on, .ctl_we, .ctl_wdata, .ctl_rdata,
                     .kick, .flag_clr, .timeout_rst, .key_rst, .wd_flag);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input bit k);
    @(negedge clk); ctl_we = 1; ctl_wdata = d; kick = k;
    @(negedge clk); ctl_we = 0; kick = 0;
  endtask

  task automatic edges_until_to(input int lim, output int n);
    n = 0;
    while (n <= lim) begin
      @(posedge clk); #1; n++;
      if (timeout_rst) break;
    end
  endtask

  task automatic t_reset;
    #1;
    chk(ctl_rdata == 8'h53, "R1", ctl_rdata, 8'h53);
    chk(!timeout_rst && !key_rst && !wd_flag, "R1", {timeout_rst, key_rst, wd_flag}, 0);
  endtask

  task automatic t_timeout(input logic [2:0] s, input int len);
    int n;
    wr({5'b01010, s}, 1);
    chk(ctl_rdata == {5'b01010, s}, "R2", ctl_rdata, {5'b01010, s});
    edges_until_to(len + 2, n);
    chk(n == len, "R4", n, len);
    chk(wd_flag, "R9 set by timeout", wd_flag, 1);
    @(posedge clk); #1;
    chk(!timeout_rst, "R5 one cycle", timeout_rst, 0);
    edges_until_to(len + 2, n);
    chk(n == len - 1, "R5 restart", n + 1, len);
  endtask

  task automatic t_kick;
    int n;
    wr(8'h50, 1);
    repeat (200) @(posedge clk);
    @(negedge clk); kick = 1; @(negedge clk); kick = 0;
    edges_until_to(300, n);
    chk(n == 256, "R6 kick clears", n, 256);
  endtask

  task automatic t_stop_sw;
    int n;
    always_on = 0;
    wr(8'hA8, 1);
    edges_until_to(600, n);
    chk(n > 600, "R7 stopped no timeout", n, 601);
    chk(!key_rst, "R3 stop key legal", key_rst, 0);
  endtask

  task automatic t_stop_key_always;
    int n;
    always_on = 1;
    wr(8'hA8, 1);
    edges_until_to(300, n);
    chk(n == 256, "R3 always_on runs", n, 256);
    always_on = 0;
  endtask

  task automatic t_badkey;
    int n = 0;
    wr(8'h50, 1);
    @(negedge clk); flag_clr = 1; @(negedge clk); flag_clr = 0;
    #1 chk(!wd_flag, "R9 clear", wd_flag, 1'b0);
    @(negedge clk); ctl_we = 1; ctl_wdata = 8'hF8;
    @(posedge clk); #1; ctl_we = 0;
    while (!key_rst && n < 5) begin @(posedge clk); #1; n++; end
    chk(n == 2, "R8 latency", n, 2);
    chk(wd_flag, "R9 set by key fault", wd_flag, 1);
    repeat (300) @(posedge clk);
    #1 chk(key_rst && !timeout_rst, "R8 held", {key_rst, timeout_rst}, 2);
    @(negedge clk); flag_clr = 1; @(negedge clk); flag_clr = 0;
    #1 chk(wd_flag, "R9 set wins over clear", wd_flag, 1);
    @(negedge clk); ctl_we = 1; ctl_wdata = 8'h50;
    @(posedge clk); #1; ctl_we = 0; n = 0;
    while (key_rst && n < 5) begin @(posedge clk); #1; n++; end
    chk(n == 2, "R8 release", n, 2);
  endtask

  task automatic t_shrink;
    int n = 0;
    wr(8'h53, 1);
    repeat (300) @(posedge clk);
    @(negedge clk); ctl_we = 1; ctl_wdata = 8'h50;
    @(posedge clk); #1; ctl_we = 0;
    chk(!timeout_rst, "R10 not on write edge", timeout_rst, 0);
    @(posedge clk); #1;
    chk(timeout_rst, "R10 next edge", timeout_rst, 1);
  endtask

  initial begin
    #150000000;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_timeout(3'b000, 256);
    t_timeout(3'b001, 1024);
    t_timeout(3'b100, 32768);
    t_kick();
    t_stop_sw();
    t_stop_key_always();
    t_badkey();
    t_shrink();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule